// File: doc/BRIEF.md
# Big-Endian Sub-Word Load/Store Aligner

This block sits between a processor core and a data memory whose port is one 32-bit word wide. The core hands it a request made of an operation code, a base address, a signed 16-bit displacement and, for stores, a source register value. The block forms the byte address and checks that the access is aligned to its size. It then either raises a misalignment response or runs a single memory access. For a load it picks the addressed byte or halfword out of the returned word and widens it to 32 bits. For a store it places the low byte or halfword of the source into its lane and drives a matching byte-enable mask.

Lanes are numbered big-endian: the byte at the lowest address of a word is carried in the most significant eight bits. A small state machine sequences every request with the states IDLE, WRITE, READ, RESP and FAULT. The transitions are:

- IDLE to FAULT when an accepted request is misaligned.
- IDLE to WRITE when an accepted store is aligned.
- IDLE to READ when an accepted load is aligned.
- READ to RESP unconditionally.
- WRITE, RESP and FAULT back to IDLE unconditionally.

The memory is assumed to return read data one clock after it samples an enabled read.

Top module: `lsa_aligner`

## Requirements
- R1: While reset is held and on the first cycle after it, the block is in IDLE, with req_ready at 1 and mem_en and rsp_valid at 0.
- R2: The byte address is req_base plus the 16-bit req_offset sign-extended to 32 bits. mem_addr carries that address with its two low bits forced to 0.
- R3: Store codes are 5 for a word, 6 for a halfword and 7 for a byte. Byte offset k (0 to 3) uses data bits 31-8k down to 24-8k and byte-enable bit 3-k. A halfword at offset 0 uses bits 31:16 with mask 1100, and at offset 2 uses bits 15:0 with mask 0011. A word uses mask 1111. Only the low byte or halfword of req_wdata is stored, and lanes that are not enabled carry 0.
- R4: Code 3 loads a byte with sign extension and code 4 loads a byte with zero extension. The byte is taken from the lane that R3 gives for its offset.
- R5: Code 1 loads a halfword with sign extension and code 2 loads a halfword with zero extension. Offset 0 yields bits 31:16 of the memory word and offset 2 yields bits 15:0.
- R6: Code 0 loads a word and returns the memory word unchanged.
- R7: A request is misaligned when a word has a nonzero low address pair or a halfword has address bit 0 set. Such a request produces one FAULT cycle with rsp_valid and rsp_misaligned at 1 and rsp_rdata at 0. It makes no memory access and drives no byte enable.
- R8: A request is accepted only in IDLE, where req_ready is 1. A store gives rsp_valid in the same cycle as its single write, one cycle after acceptance. A load drives a read for one cycle and gives rsp_valid with the data on the next cycle. Requests presented while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (R3 to R6) |
| req_base | input | 32 | Base address |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source value |
| req_ready | output | 1 | Block can accept a request (IDLE) |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write when 1, read when 0 |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane enables, bit 3 is the lowest address |
| mem_wdata | output | 32 | Lane-positioned store data |
| mem_rdata | input | 32 | Read word, valid one cycle after a read |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_misaligned | output | 1 | Response reports a misaligned request |
| rsp_rdata | output | 32 | Extended load result |

## Verification
The bound checker enforces, on every cycle, the rules that hold regardless of data. Memory addresses are always word aligned. Store masks are always one of the legal lane patterns, and disabled lanes always carry zero. A fault never coexists with a memory access. Every read is followed by a clean response, and responses last a single cycle. The actual lane choice, the sign or zero fill, the address sum with negative displacements, and the fact that requests offered while busy leave memory untouched can only be shown by the bench. It compares each response and each write against values derived from the requirements and reads the memory back afterwards.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    typedef enum logic [2:0] {
        LD_WORD   = 3'd0,
        LD_HALF_S = 3'd1,
        LD_HALF_U = 3'd2,
        LD_BYTE_S = 3'd3,
        LD_BYTE_U = 3'd4,
        SV_WORD   = 3'd5,
        SV_HALF   = 3'd6,
        SV_BYTE   = 3'd7
    } lsa_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } lsa_size_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_WRITE = 3'd1,
        S_READ  = 3'd2,
        S_RESP  = 3'd3,
        S_FAULT = 3'd4
    } lsa_state_e;

    typedef struct packed {
        lsa_size_e size;
        logic      is_store;
        logic      sign_ext;
    } lsa_dec_t;

    function automatic lsa_dec_t lsa_decode(input lsa_op_e op);
        lsa_dec_t d;
        d = '{size: SZ_WORD, is_store: 1'b0, sign_ext: 1'b0};
        unique case (op)
            LD_WORD:   d = '{size: SZ_WORD, is_store: 1'b0, sign_ext: 1'b0};
            LD_HALF_S: d = '{size: SZ_HALF, is_store: 1'b0, sign_ext: 1'b1};
            LD_HALF_U: d = '{size: SZ_HALF, is_store: 1'b0, sign_ext: 1'b0};
            LD_BYTE_S: d = '{size: SZ_BYTE, is_store: 1'b0, sign_ext: 1'b1};
            LD_BYTE_U: d = '{size: SZ_BYTE, is_store: 1'b0, sign_ext: 1'b0};
            SV_WORD:   d = '{size: SZ_WORD, is_store: 1'b1, sign_ext: 1'b0};
            SV_HALF:   d = '{size: SZ_HALF, is_store: 1'b1, sign_ext: 1'b0};
            SV_BYTE:   d = '{size: SZ_BYTE, is_store: 1'b1, sign_ext: 1'b0};
            default:   d = '{size: SZ_WORD, is_store: 1'b0, sign_ext: 1'b0};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    parameter int LANES  = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFFS_W-1:0] offset,
    input  lsa_size_e         size,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              misaligned
);
    localparam int LSB_W = $clog2(LANES);
    localparam int EXT_W = ADDR_W - OFFS_W;

    logic [ADDR_W-1:0] offset_sx;

    assign offset_sx = {{EXT_W{offset[OFFS_W-1]}}, offset};
    assign eff_addr  = base + offset_sx;

    always_comb begin
        unique case (size)
            SZ_WORD: misaligned = |eff_addr[LSB_W-1:0];
            SZ_HALF: misaligned = eff_addr[0];
            default: misaligned = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsa_size_e                     size,
    input  logic [$clog2(DATA_W/8)-1:0]   lane_off,
    input  logic [DATA_W-1:0]             src,
    output logic [DATA_W/8-1:0]           be,
    output logic [DATA_W-1:0]             wdata
);
    localparam int LANES = DATA_W / 8;
    localparam int LSB_W = $clog2(LANES);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // big-endian: lane g holds the byte at offset LANES-1-g
        localparam logic [LSB_W-1:0] OFF_V = LSB_W'(LANES - 1 - g);
        logic       hit;
        logic [7:0] half_byte;

        if (OFF_V[0] == 1'b0) begin : g_hi
            assign half_byte = src[15:8];
        end else begin : g_lo
            assign half_byte = src[7:0];
        end

        always_comb begin
            unique case (size)
                SZ_BYTE: hit = (lane_off == OFF_V);
                SZ_HALF: hit = (lane_off[LSB_W-1:1] == OFF_V[LSB_W-1:1]);
                default: hit = 1'b1;
            endcase
        end

        assign be[g] = hit;

        always_comb begin
            if (!hit) begin
                wdata[8*g +: 8] = 8'h00;
            end else begin
                unique case (size)
                    SZ_BYTE: wdata[8*g +: 8] = src[7:0];
                    SZ_HALF: wdata[8*g +: 8] = half_byte;
                    default: wdata[8*g +: 8] = src[8*g +: 8];
                endcase
            end
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsa_size_e                     size,
    input  logic                          sign_ext,
    input  logic [$clog2(DATA_W/8)-1:0]   lane_off,
    input  logic [DATA_W-1:0]             word,
    output logic [DATA_W-1:0]             result
);
    localparam int LANES = DATA_W / 8;
    localparam int LSB_W = $clog2(LANES);

    logic [7:0]  byte_at [LANES];
    logic [7:0]  pick_b;
    logic [15:0] pick_h;
    logic [LSB_W-1:0] h_hi_idx;
    logic [LSB_W-1:0] h_lo_idx;

    for (genvar o = 0; o < LANES; o++) begin : g_off
        assign byte_at[o] = word[DATA_W-1-8*o -: 8];
    end

    assign h_hi_idx = {lane_off[LSB_W-1:1], 1'b0};
    assign h_lo_idx = {lane_off[LSB_W-1:1], 1'b1};
    assign pick_b   = byte_at[lane_off];
    assign pick_h   = {byte_at[h_hi_idx], byte_at[h_lo_idx]};

    always_comb begin
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sign_ext & pick_b[7]}}, pick_b};
            SZ_HALF: result = {{(DATA_W-16){sign_ext & pick_h[15]}}, pick_h};
            default: result = word;
        endcase
    end
endmodule

// File: rtl/lsa_aligner.sv
module lsa_aligner
    import lsa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [2:0]          req_op,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [OFFS_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                req_ready,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                rsp_valid,
    output logic                rsp_misaligned,
    output logic [DATA_W-1:0]   rsp_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int LSB_W = $clog2(LANES);

    lsa_state_e        state_q, state_d;
    lsa_dec_t          dec_in, dec_q;
    logic [ADDR_W-1:0] ea_in, ea_q;
    logic              mis_in;
    logic [LANES-1:0]  be_in, be_q;
    logic [DATA_W-1:0] wd_in, wd_q;
    logic [DATA_W-1:0] ld_result;
    logic              accept;

    assign dec_in = lsa_decode(lsa_op_e'(req_op));
    assign accept = req_valid && (state_q == S_IDLE);

    lsa_addr_gen #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LANES(LANES)) u_agen (
        .base       (req_base),
        .offset     (req_offset),
        .size       (dec_in.size),
        .eff_addr   (ea_in),
        .misaligned (mis_in)
    );

    lsa_store_lanes #(.DATA_W(DATA_W)) u_slane (
        .size     (dec_in.size),
        .lane_off (ea_in[LSB_W-1:0]),
        .src      (req_wdata),
        .be       (be_in),
        .wdata    (wd_in)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_lext (
        .size     (dec_q.size),
        .sign_ext (dec_q.sign_ext),
        .lane_off (ea_q[LSB_W-1:0]),
        .word     (mem_rdata),
        .result   (ld_result)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    if (mis_in)               state_d = S_FAULT;
                    else if (dec_in.is_store) state_d = S_WRITE;
                    else                      state_d = S_READ;
                end
            end
            S_READ:  state_d = S_RESP;
            S_WRITE: state_d = S_IDLE;
            S_RESP:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dec_q   <= '{size: SZ_WORD, is_store: 1'b0, sign_ext: 1'b0};
            ea_q    <= '0;
            be_q    <= '0;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dec_q <= dec_in;
                ea_q  <= ea_in;
                be_q  <= be_in;
                wd_q  <= wd_in;
            end
        end
    end

    // outputs per state
    always_comb begin
        req_ready      = 1'b0;
        mem_en         = 1'b0;
        mem_we         = 1'b0;
        mem_be         = '0;
        mem_wdata      = '0;
        rsp_valid      = 1'b0;
        rsp_misaligned = 1'b0;
        rsp_rdata      = '0;
        mem_addr       = {ea_q[ADDR_W-1:LSB_W], {LSB_W{1'b0}}};
        unique case (state_q)
            S_IDLE: req_ready = 1'b1;
            S_WRITE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_be    = be_q;
                mem_wdata = wd_q;
                rsp_valid = 1'b1;
            end
            S_READ: begin
                mem_en = 1'b1;
                mem_be = be_q;
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = ld_result;
            end
            S_FAULT: begin
                rsp_valid      = 1'b1;
                rsp_misaligned = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_ready,
    input logic                mem_en,
    input logic                mem_we,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [DATA_W/8-1:0] mem_be,
    input logic [DATA_W-1:0]   mem_wdata,
    input logic                rsp_valid,
    input logic                rsp_misaligned,
    input logic [DATA_W-1:0]   rsp_rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int LSB_W = $clog2(LANES);

    logic [DATA_W-1:0] lane_mask;
    for (genvar g = 0; g < LANES; g++) begin : g_m
        assign lane_mask[8*g +: 8] = {8{mem_be[g]}};
    end

    AST_ADDR_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr[LSB_W-1:0] == '0)); // R2

    AST_STORE_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ($countones(mem_be) == 1 || mem_be == 4'b1100 ||
                                mem_be == 4'b0011 || mem_be == 4'b1111)); // R3

    AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> ((mem_wdata & ~lane_mask) == '0)); // R3

    AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_misaligned |-> (!mem_en && mem_be == '0 && rsp_rdata == '0 && rsp_valid)); // R7

    AST_READ_THEN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> (rsp_valid && !rsp_misaligned && !mem_en)); // R8

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_en) |-> !req_ready); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        $rose(rst_n) |-> (req_ready && !mem_en && !rsp_valid)); // R1
endmodule

bind lsa_aligner lsa_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_ready      (req_ready),
    .mem_en         (mem_en),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_be         (mem_be),
    .mem_wdata      (mem_wdata),
    .rsp_valid      (rsp_valid),
    .rsp_misaligned (rsp_misaligned),
    .rsp_rdata      (rsp_rdata)
);

// File: tb/lsa_aligner_bench.sv
module lsa_aligner_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, mem_en, mem_we, rsp_valid, rsp_misaligned;
    logic [31:0] mem_addr, mem_wdata, rsp_rdata;
    logic [31:0] mem_rdata = '0;
    logic [3:0]  mem_be;

    always #5 clk = ~clk;

    lsa_aligner u_lsa_aligner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_base(req_base), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_ready(req_ready), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_misaligned(rsp_misaligned), .rsp_rdata(rsp_rdata)
    );

    int checks = 0;
    int errors = 0;
    int writes = 0;
    int cycles = 0;

    // bench memory: 16 words, one cycle read latency
    logic [31:0] ram [16];
    logic [31:0] shadow [16];
    initial for (int i = 0; i < 16; i++) begin ram[i] = '0; shadow[i] = '0; end

    always @(posedge clk) begin
        if (rst_n && mem_en) begin
            if (mem_we) begin
                writes++;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) ram[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= ram[mem_addr[5:2]];
            end
        end
    end

    typedef struct {
        int          kind;   // 0 load, 1 store, 2 fault
        logic [31:0] data;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor
    logic [31:0] last_rd_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_en && !mem_we) last_rd_addr = mem_addr;
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected response", rsp_rdata, 32'h0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.kind == 2) begin
                        check(rsp_misaligned == 1'b1, e.tag, "fault flag", {31'h0, rsp_misaligned}, 32'h1);
                        check(!mem_en && mem_be == 4'h0 && rsp_rdata == 32'h0, e.tag,
                              "fault with access", {27'h0, mem_en, mem_be}, 32'h0);
                    end else if (e.kind == 1) begin
                        check(!rsp_misaligned && mem_en && mem_we, e.tag, "store cycle",
                              {30'h0, mem_en, mem_we}, 32'h3);
                        check(mem_be == e.be, e.tag, "store mask", {28'h0, mem_be}, {28'h0, e.be});
                        check(mem_wdata == e.wdata, e.tag, "store data", mem_wdata, e.wdata);
                        check(mem_addr == e.addr, "R2", "store addr", mem_addr, e.addr);
                    end else begin
                        check(!rsp_misaligned, e.tag, "load flag", {31'h0, rsp_misaligned}, 32'h0);
                        check(rsp_rdata == e.data, e.tag, "load data", rsp_rdata, e.data);
                        check(last_rd_addr == e.addr, "R2", "load addr", last_rd_addr, e.addr);
                    end
                end
            end
        end
    end

    // driver: compute expectation from the requirements, push, then drive
    task automatic issue(input logic [2:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] wd, input string tag);
        exp_t e;
        logic [31:0] ea, w;
        logic [1:0]  o;
        logic [7:0]  bv;
        logic [15:0] hv;
        int          sz; // 1 byte, 2 half, 4 word
        ea = base + {{16{off[15]}}, off};
        o  = ea[1:0];
        sz = (op == 0 || op == 5) ? 4 : (op == 1 || op == 2 || op == 6) ? 2 : 1;
        e.tag = tag; e.addr = {ea[31:2], 2'b00}; e.data = '0; e.be = '0; e.wdata = '0;
        if ((sz == 4 && o != 0) || (sz == 2 && o[0])) begin
            e.kind = 2;
        end else if (op >= 5) begin
            e.kind = 1;
            if (sz == 4) begin
                e.be = 4'hF; e.wdata = wd;
            end else if (sz == 2) begin
                e.be    = o[1] ? 4'b0011 : 4'b1100;
                e.wdata = o[1] ? {16'h0, wd[15:0]} : {wd[15:0], 16'h0};
            end else begin
                e.be    = 4'b1000 >> o;
                e.wdata = {wd[7:0], 24'h0} >> (8 * o);
            end
            for (int b = 0; b < 4; b++)
                if (e.be[b]) shadow[ea[5:2]][8*b +: 8] = e.wdata[8*b +: 8];
        end else begin
            e.kind = 0;
            w  = shadow[ea[5:2]];
            bv = 8'(w >> (24 - 8 * o));
            hv = o[1] ? w[15:0] : w[31:16];
            case (op)
                3'd0: e.data = w;
                3'd1: e.data = {{16{hv[15]}}, hv};
                3'd2: e.data = {16'h0, hv};
                3'd3: e.data = {{24{bv[7]}}, bv};
                default: e.data = {24'h0, bv};
            endcase
        end
        sb_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_base = base; req_offset = off; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int w0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values while held
        check(req_ready == 1'b1, "R1", "ready in reset", {31'h0, req_ready}, 32'h1);
        check(mem_en == 1'b0, "R1", "mem_en in reset", {31'h0, mem_en}, 32'h0);
        check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !mem_en && !rsp_valid, "R1", "idle after reset",
              {29'h0, req_ready, mem_en, rsp_valid}, 32'h4);

        // R6/R2 word store and load, negative displacement
        issue(3'd5, 32'h0000_1010, 16'hFFF0, 32'h8123_45F6, "R3");
        issue(3'd0, 32'h0000_1000, 16'h0000, 32'h0, "R6");
        issue(3'd0, 32'h0000_0FF0, 16'h0010, 32'h0, "R2");
        // R4 byte loads, all offsets, both extensions
        for (int k = 0; k < 4; k++) begin
            issue(3'd3, 32'h0000_1000, 16'(k), 32'h0, "R4");
            issue(3'd4, 32'h0000_1000, 16'(k), 32'h0, "R4");
        end
        // R5 halfword loads
        issue(3'd1, 32'h0000_1000, 16'd0, 32'h0, "R5");
        issue(3'd2, 32'h0000_1000, 16'd0, 32'h0, "R5");
        issue(3'd1, 32'h0000_1000, 16'd2, 32'h0, "R5");
        issue(3'd2, 32'h0000_1000, 16'd2, 32'h0, "R5");
        // R3 byte stores to each lane, halfword stores, readback
        issue(3'd5, 32'h0000_1004, 16'd0, 32'h0000_0000, "R3");
        for (int k = 0; k < 4; k++)
            issue(3'd7, 32'h0000_1004, 16'(k), 32'hDEAD_BE00 | 32'(8'hA0 + k), "R3");
        issue(3'd0, 32'h0000_1004, 16'd0, 32'h0, "R3");
        issue(3'd6, 32'h0000_1008, 16'd2, 32'hABCD_9234, "R3");
        issue(3'd6, 32'h0000_1008, 16'd0, 32'h5555_7E11, "R3");
        issue(3'd0, 32'h0000_1008, 16'd0, 32'h0, "R3");
        issue(3'd1, 32'h0000_1008, 16'd2, 32'h0, "R5");
        // R7 misaligned requests
        issue(3'd0, 32'h0000_1001, 16'd0, 32'h0, "R7");
        issue(3'd5, 32'h0000_1002, 16'd0, 32'hFFFF_FFFF, "R7");
        issue(3'd6, 32'h0000_1003, 16'd0, 32'hFFFF_FFFF, "R7");
        issue(3'd1, 32'h0000_1000, 16'd1, 32'h0, "R7");
        issue(3'd7, 32'h0000_1003, 16'd0, 32'h0000_0077, "R3");
        issue(3'd0, 32'h0000_1000, 16'd0, 32'h0, "R7");

        // R8: a store presented while busy with a load is ignored
        w0 = writes;
        sb_q.push_back('{kind: 0, data: shadow[0], addr: 32'h0000_1000, be: 4'h0, wdata: 32'h0, tag: "R8"});
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'd0; req_base = 32'h0000_1000; req_offset = 16'd0;
        @(posedge clk);
        @(negedge clk);
        req_op = 3'd5; req_base = 32'h0000_1014; req_wdata = 32'h1234_5678;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(writes == w0, "R8", "write while busy", 32'(writes), 32'(w0));
        issue(3'd0, 32'h0000_1014, 16'd0, 32'h0, "R8");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R8", "responses outstanding", 32'(sb_q.size()), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule